// File: doc/BRIEF.md
# PWM Unit with Emergency Shutdown

This block is a multi-channel pulse-width modulator with an emergency stop path. Each channel owns an up-counter, a period register and a duty register. Its output is high while the counter is below the duty value. Adjacent channels can be joined into one 16-bit channel. New period and duty values are taken only when the counter wraps.

The highest-numbered channel never produces a waveform. Its pin is a pure input that serves as the shutdown request. When shutdown is enabled and this input is at its active level, every remaining output is forced to a per-channel idle level held in a register. The input passes through a synchroniser first, and its active polarity is programmable.

Once the request goes away, forcing stays in place until software asks for a restart. Each channel then resumes at its own counter wrap, so the first pulse it drives is always a whole one. A halt input freezes all counters and parks the outputs on their idle levels. Software reaches the block through a write-only register port.

Top module: `pwm_sd_top`

## Requirements
- R1: Each channel counts from 0 to max(P,1)-1, where P is the period register at address 0x08+ch. Its output is high while the count is below the duty register D at address 0x10+ch, so it is high min(D,max(P,1)) cycles in every period. The enable register at address 0x00 (bit = channel) must be set for a channel to run, and a disabled channel drives 0. Period and duty writes take effect at the next wrap.
- R2: The control register at address 0x02 has these fields: bit0 enables shutdown, and bit1 selects the active level (1 = high, 0 = low). While shutdown is enabled and the synchronised pin matches the active level, every output 0..6 equals its bit of the level register at address 0x01, from the fourth clock edge after the pin changes.
- R3: Writing 1 to bit2 of the control register requests a restart. Once the pin is inactive, each forced channel returns to PWM at its own counter wrap, so its first pulse after release has the full duty length.
- R4: If the pin deasserts and no restart is requested, the outputs stay at the level register values indefinitely. A later restart request releases them.
- R5: Bit p of the register at address 0x03 (p = 0..2) joins channel 2p (low byte) and channel 2p+1 (high byte) into one 16-bit counter, period and duty. The waveform appears on channel 2p+1, and channel 2p drives 0. Under shutdown both channels hold their level for the whole 16-bit period, and release happens only at the 16-bit wrap.
- R6: The shutdown flag output rises when shutdown becomes active. It is cleared by writing 1 to bit3 of the control register, and it does not rise again while the same shutdown persists.
- R7: While the halt input is high, all counters hold their value, and each output shows its level register bit one cycle later.
- R8: Channel 7 never produces a waveform, even when its enable bit is set. No output data of the unit can trigger a shutdown.
- R9: After reset all outputs are 0, the flag is 0 and shutdown is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| halt_i | input | 1 | Low-power halt: freeze counters, park outputs at level |
| sd_pin_i | input | 1 | Shutdown request pin (channel 7 pin, input only) |
| pwm_o | output | 7 | Registered outputs of channels 0..6 |
| sd_flag_o | output | 1 | Shutdown entry flag |

## Verification
A register write takes effect at the clock edge that samples it. A change on the shutdown pin reaches the outputs four edges later: two synchroniser stages, the force register and the output register. Halt reaches the outputs after one edge, and after a release the first PWM value appears one edge after the wrap. The checks therefore wait at least five cycles after each stimulus before comparing forced levels. Waveforms are judged by counting high samples over whole multiples of the period, so the checks never depend on counter phase. Restart timing is judged by the length of the first pulse after release: releasing anywhere other than the wrap would shorten that pulse.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CHEN = 5'h00;
  localparam logic [ADDR_W-1:0] A_LVL  = 5'h01;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h02;
  localparam logic [ADDR_W-1:0] A_PAIR = 5'h03;
  localparam logic [ADDR_W-1:0] A_PER  = 5'h08;
  localparam logic [ADDR_W-1:0] A_DUTY = 5'h10;
  // control register bit positions
  localparam int C_EN  = 0;
  localparam int C_POL = 1;
  localparam int C_RST = 2;
  localparam int C_CLR = 3;
endpackage

// File: rtl/pwm_sd_sync.sv
module pwm_sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end
  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_sd_pair.sv
module pwm_sd_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          en_lo,
  input  logic          en_hi,
  input  logic          concat,
  input  logic [CW-1:0] per_lo,
  input  logic [CW-1:0] per_hi,
  input  logic [CW-1:0] duty_lo,
  input  logic [CW-1:0] duty_hi,
  output logic          out_lo,
  output logic          out_hi,
  output logic          wrap_lo,
  output logic          wrap_hi
);
  localparam int DW = 2 * CW;

  logic [CW-1:0] cnt_lo, cnt_hi, sp_lo, sp_hi, sd_lo, sd_hi;
  logic [DW-1:0] w_cnt, w_per, w_duty;
  logic          last_w, last_lo, last_hi;

  assign w_cnt  = {cnt_hi, cnt_lo};
  assign w_per  = {sp_hi, sp_lo};
  assign w_duty = {sd_hi, sd_lo};

  assign last_w  = (w_per <= DW'(1)) || (w_cnt == w_per - DW'(1));
  assign last_lo = (sp_lo <= CW'(1)) || (cnt_lo == sp_lo - CW'(1));
  assign last_hi = (sp_hi <= CW'(1)) || (cnt_hi == sp_hi - CW'(1));

  always_comb begin
    if (concat) begin
      out_lo  = 1'b0;
      out_hi  = en_hi && (w_cnt < w_duty);
      wrap_lo = !en_hi || last_w;
      wrap_hi = !en_hi || last_w;
    end else begin
      out_lo  = en_lo && (cnt_lo < sd_lo);
      out_hi  = en_hi && (cnt_hi < sd_hi);
      wrap_lo = !en_lo || last_lo;
      wrap_hi = !en_hi || last_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0; cnt_hi <= '0;
      sp_lo  <= '0; sp_hi  <= '0;
      sd_lo  <= '0; sd_hi  <= '0;
    end else if (!hold_i) begin
      if (concat) begin
        if (!en_hi || last_w) begin
          {cnt_hi, cnt_lo} <= '0;
          sp_lo <= per_lo;  sp_hi <= per_hi;
          sd_lo <= duty_lo; sd_hi <= duty_hi;
        end else begin
          {cnt_hi, cnt_lo} <= w_cnt + DW'(1);
        end
      end else begin
        if (!en_lo || last_lo) begin
          cnt_lo <= '0; sp_lo <= per_lo; sd_lo <= duty_lo;
        end else begin
          cnt_lo <= cnt_lo + CW'(1);
        end
        if (!en_hi || last_hi) begin
          cnt_hi <= '0; sp_hi <= per_hi; sd_hi <= duty_hi;
        end else begin
          cnt_hi <= cnt_hi + CW'(1);
        end
      end
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (w_cnt == $past(w_cnt))); // R7

endmodule

// File: rtl/pwm_sd_top.sv
module pwm_sd_top
  import pwm_sd_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              halt_i,
  input  logic              sd_pin_i,
  output logic [NUM_CH-2:0] pwm_o,
  output logic              sd_flag_o
);
  localparam int NOUT  = NUM_CH - 1;
  localparam int NPAIR = NUM_CH / 2;

  logic [NOUT-1:0]    ch_en_q, lvl_q, force_q;
  logic [NPAIR-2:0]   pair_q;
  logic [CW-1:0]      per_q  [NUM_CH];
  logic [CW-1:0]      duty_q [NUM_CH];
  logic               sd_en_q, sd_pol_q, rst_req_q, sd_act_q, flag_q;
  logic               pin_s, sd_act, ctrl_wr;
  logic [NUM_CH-1:0]  raw, wrap;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en_q  <= '0;
      lvl_q    <= '0;
      pair_q   <= '0;
      sd_en_q  <= 1'b0;
      sd_pol_q <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == A_CHEN) ch_en_q <= wr_data[NOUT-1:0];
      if (wr_addr == A_LVL)  lvl_q   <= wr_data[NOUT-1:0];
      if (wr_addr == A_PAIR) pair_q  <= wr_data[NPAIR-2:0];
      if (wr_addr == A_CTRL) begin
        sd_en_q  <= wr_data[C_EN];
        sd_pol_q <= wr_data[C_POL];
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_addr == A_PER  + ADDR_W'(i)) per_q[i]  <= wr_data;
        if (wr_addr == A_DUTY + ADDR_W'(i)) duty_q[i] <= wr_data;
      end
    end
  end

  // shutdown pin: input only, synchronised before use
  pwm_sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sd_pin_i),
    .q   (pin_s)
  );

  assign sd_act = sd_en_q && (pin_s == sd_pol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_q <= 1'b0;
      sd_act_q  <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      sd_act_q <= sd_act;
      if (ctrl_wr && wr_data[C_RST]) rst_req_q <= 1'b1;
      else if (force_q == '0)        rst_req_q <= 1'b0;
      if (sd_act && !sd_act_q)       flag_q <= 1'b1;
      else if (ctrl_wr && wr_data[C_CLR]) flag_q <= 1'b0;
    end
  end
  assign sd_flag_o = flag_q;

  // counter pairs; the last pair's upper channel is the shutdown pin
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic cat, en_h;
    if (p == NPAIR - 1) begin : g_last
      assign cat  = 1'b0;
      assign en_h = 1'b0;
    end else begin : g_mid
      assign cat  = pair_q[p];
      assign en_h = ch_en_q[2*p+1];
    end
    pwm_sd_pair #(.CW(CW)) u_pair (
      .clk     (clk),
      .rst     (rst),
      .hold_i  (halt_i),
      .en_lo   (ch_en_q[2*p]),
      .en_hi   (en_h),
      .concat  (cat),
      .per_lo  (per_q[2*p]),
      .per_hi  (per_q[2*p+1]),
      .duty_lo (duty_q[2*p]),
      .duty_hi (duty_q[2*p+1]),
      .out_lo  (raw[2*p]),
      .out_hi  (raw[2*p+1]),
      .wrap_lo (wrap[2*p]),
      .wrap_hi (wrap[2*p+1])
    );
  end

  // forcing and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= '0;
      pwm_o   <= '0;
    end else begin
      for (int i = 0; i < NOUT; i++) begin
        if (sd_act)                                force_q[i] <= 1'b1;
        else if (rst_req_q && wrap[i] && !halt_i)  force_q[i] <= 1'b0;
        pwm_o[i] <= (force_q[i] || halt_i) ? lvl_q[i] : raw[i];
      end
    end
  end

  AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    sd_act |=> ##1 (pwm_o == $past(lvl_q))); // R2

  AST_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (sd_act && !sd_act_q) |=> sd_flag_o); // R6

  AST_CH7_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!raw[NUM_CH-1] && wrap[NUM_CH-1])); // R8

  for (genvar i = 0; i < NOUT; i++) begin : g_chk
    AST_RELEASE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      $fell(force_q[i]) |-> $past(wrap[i])); // R3
    AST_HOLD_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (force_q[i] && !rst_req_q) |=> force_q[i]); // R4
  end

endmodule

// File: tb/pwm_sd_top_tb.sv
module pwm_sd_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic       halt_i;
  logic       sd_pin_i;
  logic [6:0] pwm_o;
  logic       sd_flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_sd_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .halt_i    (halt_i),
    .sd_pin_i  (sd_pin_i),
    .pwm_o     (pwm_o),
    .sd_flag_o (sd_flag_o)
  );

  // {period, duty, expected highs per period, effective period}
  localparam int VEC [7][4] = '{
    '{10, 3, 3, 10}, '{10, 0, 0, 10}, '{10, 10, 10, 10}, '{10, 200, 10, 10},
    '{7, 1, 1, 7},   '{1, 1, 1, 1},   '{0, 5, 1, 1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o[ch]) c++;
    end
  endtask

  task automatic count_mismatch(input logic [6:0] exp, input int n, output int m);
    m = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o !== exp) m++;
    end
  endtask

  task automatic pulse_len(input int ch, output int len);
    int t = 0;
    len = 0;
    @(negedge clk);
    while (!pwm_o[ch] && t < 3000) begin
      @(negedge clk);
      t++;
    end
    while (pwm_o[ch] && len < 3000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, m, len;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    halt_i = 1'b0; sd_pin_i = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R9: reset state
    chk(pwm_o == 7'h00, "R9 outputs after reset", pwm_o, 0);
    chk(sd_flag_o == 1'b0, "R9 flag after reset", sd_flag_o, 0);

    // R1: vector table on channel 3, channel 0 left disabled
    wr(5'h00, 8'h08);
    for (int v = 0; v < 7; v++) begin
      wr(5'h0B, VEC[v][0]);
      wr(5'h13, VEC[v][1]);
      idle(40);
      count_high(3, 4 * VEC[v][3], c);
      chk(c == 4 * VEC[v][2], $sformatf("R1 vector %0d high count", v), c, 4 * VEC[v][2]);
    end
    count_high(0, 50, c);
    chk(c == 0, "R1 disabled channel low", c, 0);

    // R8: channel 7 enabled with a waveform, shutdown armed, pin inactive
    wr(5'h0B, 10); wr(5'h13, 3);
    wr(5'h0F, 10); wr(5'h17, 5);
    wr(5'h00, 8'h88);
    wr(5'h02, 8'h03);
    count_high(3, 200, c);
    chk(c == 60 && sd_flag_o == 1'b0, "R8 no self shutdown", c, 60);

    // R2: forced levels during shutdown
    wr(5'h08, 10); wr(5'h10, 3);
    wr(5'h09, 7);  wr(5'h11, 4);
    wr(5'h0A, 12); wr(5'h12, 6);
    wr(5'h01, 8'h55);
    wr(5'h00, 8'h0F);
    idle(30);
    sd_pin_i = 1'b1;
    idle(5);
    count_mismatch(7'h55, 100, m);
    chk(m == 0, "R2 outputs at level", m, 0);
    // R6: flag set and cleared
    chk(sd_flag_o == 1'b1, "R6 flag set on entry", sd_flag_o, 1);
    wr(5'h02, 8'h0B);
    idle(1);
    chk(sd_flag_o == 1'b0, "R6 flag cleared", sd_flag_o, 0);
    idle(20);
    chk(sd_flag_o == 1'b0, "R6 flag stays clear while active", sd_flag_o, 0);

    // R4: release without restart keeps outputs forced
    sd_pin_i = 1'b0;
    idle(5);
    count_mismatch(7'h55, 300, m);
    chk(m == 0, "R4 held without restart", m, 0);
    // R3: restart releases at the wrap, full first pulse
    wr(5'h02, 8'h07);
    pulse_len(3, len);
    chk(len == 3, "R3 first pulse after restart", len, 3);
    count_high(3, 100, c);
    chk(c == 30, "R3 resumed waveform", c, 30);

    // R2: active-low polarity
    wr(5'h02, 8'h01);
    idle(5);
    count_mismatch(7'h55, 50, m);
    chk(m == 0, "R2 active low forces level", m, 0);
    sd_pin_i = 1'b1;
    wr(5'h02, 8'h05);
    idle(40);
    count_high(3, 100, c);
    chk(c == 30, "R2 active low released", c, 30);

    // R5: 16-bit pair 0, period 300, duty 200
    wr(5'h02, 8'h00);
    sd_pin_i = 1'b0;
    wr(5'h08, 8'h2C); wr(5'h09, 8'h01);
    wr(5'h10, 8'hC8); wr(5'h11, 8'h00);
    wr(5'h03, 8'h01);
    wr(5'h00, 8'h0B);
    idle(700);
    count_high(1, 600, c);
    chk(c == 400, "R5 16-bit high count", c, 400);
    count_high(0, 300, c);
    chk(c == 0, "R5 low channel idle in pair", c, 0);
    wr(5'h02, 8'h03);
    sd_pin_i = 1'b1;
    idle(6);
    sd_pin_i = 1'b0;
    count_mismatch(7'h55, 400, m);
    chk(m == 0, "R5 level held over 16-bit period", m, 0);
    wr(5'h02, 8'h07);
    pulse_len(1, len);
    chk(len == 200, "R5 restart at 16-bit wrap", len, 200);

    // R7: halt parks outputs at level
    wr(5'h02, 8'h00);
    wr(5'h03, 8'h00);
    wr(5'h01, 8'h2A);
    idle(20);
    halt_i = 1'b1;
    idle(2);
    count_mismatch(7'h2A, 50, m);
    chk(m == 0, "R7 outputs at level during halt", m, 0);
    halt_i = 1'b0;
    idle(20);
    count_high(3, 100, c);
    chk(c == 30, "R7 waveform after halt", c, 30);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule